// File: doc/BRIEF.md
# Multi-Channel Logic Trigger Matcher

The block watches a stream of 16-bit logic samples and decides, sample by sample, whether the programmed trigger condition is met. Each channel has four configuration bits: an ignore bit, a level bit, an edge-select bit and a channel enable. Together these bits express five conditions: high level, low level, rising edge, falling edge and any edge. Edges are found by comparing the current valid sample with the previous valid sample.

The first valid sample that satisfies every participating channel produces a one-cycle `trig_o` pulse and sets the sticky `triggered_o` flag. Later matches produce nothing until `rearm_i` clears the flag. The matcher also holds neutral secondary stages. Each has an all-ones 8-bit ignore pattern and a pass-through logic code, so they always pass and never change the result.

Top module: `trig_matcher`

## Requirements
- R1: After reset `trig_o` and `triggered_o` are 0. The ignore register resets to all ones, the level and edge registers reset to 0, and the enable register resets to all ones.
- R2: When `cfg_wr_i` is high, `cfg_data_i` is written to the register chosen by `cfg_sel_i`: 0 for ignore, 1 for level, 2 for edge, 3 for enable. A write applies to samples presented from the next cycle onward.
- R3: An enabled channel with ignore 0 and edge 0 passes only when its sample bit equals its level bit.
- R4: An enabled channel with ignore 0 and edge 1 passes only on a directed edge, where the previous valid bit is the inverse of the level bit and the current bit equals it. Level 1 gives a rising edge and level 0 a falling edge.
- R5: An enabled channel with ignore 1 and edge 1 passes when its current bit differs from its previous valid bit (any edge).
- R6: A channel whose enable bit is 0 always passes, whatever its other bits hold.
- R7: A valid sample matches when every channel passes in that same sample. If no channel participates, the first valid sample while armed matches.
- R8: A matching valid sample taken while `triggered_o` is 0 gives `trig_o` = 1 for exactly the following cycle, and `triggered_o` rises at the same time. `triggered_o` then stays at 1 and no further pulse occurs.
- R9: When `rearm_i` is high, `triggered_o` and `trig_o` are 0 in the next cycle, even if the sample in the same cycle matches. Edge history is kept across the rearm.
- R10: A sample with `sample_valid_i` low does not match and does not update the edge history. Edge conditions cannot pass until a valid sample has been seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 16 | Logic sample word |
| cfg_wr_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Register select (0 ignore, 1 level, 2 edge, 3 enable) |
| cfg_data_i | input | 16 | Per-channel write data |
| rearm_i | input | 1 | Clear the sticky flag and re-arm |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky triggered flag |

## Verification
The assertions assume that `rearm_i` and `sample_valid_i` are driven to known values in every cycle after reset. They also assume that nothing other than the valid, rearm and sticky-flag inputs decides pulse timing. The bench drives every input at the falling edge and holds it through the rising edge. It mixes directed condition sequences with a random phase, in which rearm pulses and configuration writes are sparse enough that triggers still occur. A behavioural model tracks the configuration, the history and the flag, and its outputs are compared with the design in every cycle.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
  typedef enum logic [1:0] {
    SEL_IGNORE = 2'd0,
    SEL_LEVEL  = 2'd1,
    SEL_EDGE   = 2'd2,
    SEL_ENABLE = 2'd3
  } cfg_sel_e;

  localparam logic [1:0] STAGE_CODE_PASS = 2'd2;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_match_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [NUM_CH-1:0] data_i,
  output logic [NUM_CH-1:0] ignore_o,
  output logic [NUM_CH-1:0] level_o,
  output logic [NUM_CH-1:0] edge_o,
  output logic [NUM_CH-1:0] enable_o
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ignore_o <= '1;
      level_o  <= '0;
      edge_o   <= '0;
      enable_o <= '1;
    end else if (wr_i) begin
      unique case (sel)
        SEL_IGNORE: ignore_o <= data_i;
        SEL_LEVEL:  level_o  <= data_i;
        SEL_EDGE:   edge_o   <= data_i;
        SEL_ENABLE: enable_o <= data_i;
      endcase
    end
  end
endmodule

// File: rtl/trig_chan_cond.sv
module trig_chan_cond (
  input  logic en_i,
  input  logic ignore_i,
  input  logic level_i,
  input  logic edge_i,
  input  logic cur_i,
  input  logic prev_i,
  input  logic hist_ok_i,
  output logic pass_o
);
  always_comb begin
    if (!en_i) begin
      pass_o = 1'b1;
    end else if (!ignore_i) begin
      if (edge_i) pass_o = hist_ok_i && (cur_i == level_i) && (prev_i != level_i);
      else        pass_o = (cur_i == level_i);
    end else if (edge_i) begin
      pass_o = hist_ok_i && (cur_i != prev_i);
    end else begin
      pass_o = 1'b1;
    end
  end
endmodule

// File: rtl/trig_neutral_stage.sv
module trig_neutral_stage
  import trig_match_pkg::*;
#(
  parameter int unsigned STAGE_W = 8
) (
  input  logic [STAGE_W-1:0] sample_i,
  output logic               pass_o
);
  // fixed neutral setting: all bits ignored, pass-through combine code
  localparam logic [STAGE_W-1:0] IGN   = '1;
  localparam logic [STAGE_W-1:0] VAL   = '0;
  localparam logic [1:0]         CODE  = STAGE_CODE_PASS;

  logic masked_eq;
  assign masked_eq = ((sample_i & ~IGN) == (VAL & ~IGN));
  assign pass_o    = (CODE == STAGE_CODE_PASS) ? masked_eq : 1'b0;
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_match_pkg::*;
#(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned STAGE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [NUM_CH-1:0] sample_i,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [NUM_CH-1:0] cfg_data_i,
  input  logic              rearm_i,
  output logic              trig_o,
  output logic              triggered_o
);
  localparam int unsigned NUM_AUX = (NUM_STAGES > 1) ? NUM_STAGES - 1 : 1;

  logic [NUM_CH-1:0] ign, lvl, edg, ena;
  logic [NUM_CH-1:0] prev_q;
  logic              hist_ok_q;
  logic [NUM_CH-1:0] ch_pass;
  logic [NUM_AUX-1:0] aux_pass;
  logic              match;

  trig_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .ignore_o (ign),
    .level_o  (lvl),
    .edge_o   (edg),
    .enable_o (ena)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trig_chan_cond u_cond (
      .en_i      (ena[c]),
      .ignore_i  (ign[c]),
      .level_i   (lvl[c]),
      .edge_i    (edg[c]),
      .cur_i     (sample_i[c]),
      .prev_i    (prev_q[c]),
      .hist_ok_i (hist_ok_q),
      .pass_o    (ch_pass[c])
    );
  end

  if (NUM_STAGES > 1) begin : g_aux
    for (genvar s = 0; s < NUM_AUX; s++) begin : g_stage
      trig_neutral_stage #(.STAGE_W(STAGE_W)) u_stage (
        .sample_i (sample_i[STAGE_W-1:0]),
        .pass_o   (aux_pass[s])
      );
    end
  end else begin : g_no_aux
    assign aux_pass = '1;
  end

  assign match = sample_valid_i && (&ch_pass) && (&aux_pass);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      hist_ok_q <= 1'b0;
    end else if (sample_valid_i) begin
      prev_q    <= sample_i;
      hist_ok_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o      <= 1'b0;
      triggered_o <= 1'b0;
    end else if (rearm_i) begin
      trig_o      <= 1'b0;
      triggered_o <= 1'b0;
    end else if (match && !triggered_o) begin
      trig_o      <= 1'b1;
      triggered_o <= 1'b1;
    end else begin
      trig_o      <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_valid_i,
  input logic rearm_i,
  input logic trig_o,
  input logic triggered_o
);
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> triggered_o); // R8
  AST_NO_REPULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triggered_o |=> !trig_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !rearm_i) |=> triggered_o); // R8
  AST_REARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (!triggered_o && !trig_o)); // R9
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $past(sample_valid_i)); // R10
  AST_FLAG_RISE_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> trig_o); // R8
endmodule

bind trig_matcher trig_matcher_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .rearm_i        (rearm_i),
  .trig_o         (trig_o),
  .triggered_o    (triggered_o)
);

// File: tb/trig_matcher_tb_top.sv
`timescale 1ns/1ps
module trig_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] sample = '0;
  logic        wr = 1'b0;
  logic [1:0]  sel = '0;
  logic [15:0] data = '0;
  logic        rearm = 1'b0;
  logic        trig, trgd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [15:0] m_ign, m_lvl, m_edg, m_ena, m_prev;
  bit m_hok, m_trig, m_trgd;

  always #2.5 clk = ~clk;

  trig_matcher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(sample),
    .cfg_wr_i(wr), .cfg_sel_i(sel), .cfg_data_i(data), .rearm_i(rearm),
    .trig_o(trig), .triggered_o(trgd)
  );

  task automatic model_reset();
    m_ign = '1; m_lvl = '0; m_edg = '0; m_ena = '1; m_prev = '0;
    m_hok = 0; m_trig = 0; m_trgd = 0;
  endtask

  function automatic bit model_match(logic [15:0] s);
    bit ok = 1;
    for (int c = 0; c < 16; c++) begin
      if (!m_ena[c]) continue;
      if (!m_ign[c] && !m_edg[c] && s[c] != m_lvl[c]) ok = 0;
      if (!m_ign[c] && m_edg[c] &&
          !(m_hok && s[c] == m_lvl[c] && m_prev[c] != m_lvl[c])) ok = 0;
      if (m_ign[c] && m_edg[c] && !(m_hok && s[c] != m_prev[c])) ok = 0;
    end
    return ok;
  endfunction

  task automatic model_clock();
    bit mt = valid && model_match(sample);
    if (rearm) begin m_trig = 0; m_trgd = 0; end
    else if (mt && !m_trgd) begin m_trig = 1; m_trgd = 1; end
    else m_trig = 0;
    if (valid) begin m_prev = sample; m_hok = 1; end
    if (wr) case (sel)
      2'd0: m_ign = data;
      2'd1: m_lvl = data;
      2'd2: m_edg = data;
      default: m_ena = data;
    endcase
  endtask

  task automatic compare();
    checks++;
    if (trig !== m_trig || trgd !== m_trgd) begin
      errors++;
      $display("FAIL %s: trig/triggered actual %b/%b expected %b/%b at %0t",
               tag, trig, trgd, m_trig, m_trgd, $time);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] s, input logic w,
                      input logic [1:0] sl, input logic [15:0] d, input logic ra);
    @(negedge clk);
    compare();
    valid = v; sample = s; wr = w; sel = sl; data = d; rearm = ra;
    @(posedge clk);
    model_clock();
  endtask

  task automatic smp(input logic [15:0] s); step(1, s, 0, 0, '0, 0); endtask
  task automatic cfg(input logic [1:0] sl, input logic [15:0] d); step(0, '0, 1, sl, d, 0); endtask
  task automatic arm(); step(0, '0, 0, 0, '0, 1); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; valid = 0; wr = 0; rearm = 0; sample = '0; data = '0; sel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    @(posedge clk); model_clock();
  endtask

  initial begin
    do_reset();
    // R7: nothing participates, first valid fires
    tag = "R7"; smp(16'h1234);
    tag = "R8"; smp(16'h1234); smp(16'hffff); step(0, '0, 0, 0, '0, 0);
    // R9: rearm with matching sample suppresses pulse
    tag = "R9"; step(1, 16'h0f0f, 0, 0, '0, 1); step(0, '0, 0, 0, '0, 0); smp(16'h0001);
    step(0, '0, 0, 0, '0, 0);
    // R2, R3: level high on ch0
    tag = "R2"; arm(); cfg(2'd0, 16'hfffe); cfg(2'd1, 16'h0001);
    tag = "R3"; smp(16'h0000); smp(16'hfffe); smp(16'h0001); smp(16'h0000);
    // R3: level low on ch0
    arm(); cfg(2'd1, 16'h0000); smp(16'h0001); smp(16'h0000); smp(16'h0000);
    // R4: rising on ch3
    tag = "R4"; arm(); cfg(2'd0, 16'hfff7); cfg(2'd1, 16'h0008); cfg(2'd2, 16'h0008);
    smp(16'h0008); smp(16'h0008); smp(16'h0000); smp(16'h0000); smp(16'h0008); smp(16'h0000);
    // R4: falling on ch3
    arm(); cfg(2'd1, 16'h0000); smp(16'h0000); smp(16'h0008); smp(16'h0008); smp(16'h0000);
    // R5: any edge on ch5
    tag = "R5"; arm(); cfg(2'd0, 16'hffff); cfg(2'd2, 16'h0020); cfg(2'd1, 16'h0000);
    smp(16'h0020); smp(16'h0020); smp(16'h0000); arm(); smp(16'h0000); smp(16'h0020);
    // R10: invalid toggles ignored for history
    tag = "R10"; arm(); smp(16'h0020); step(0, 16'h0000, 0, 0, '0, 0);
    step(0, 16'h0000, 0, 0, '0, 0); smp(16'h0020); smp(16'h0020); smp(16'h0000);
    // R6: disabling ch5 makes first valid fire
    tag = "R6"; arm(); smp(16'h0000); cfg(2'd3, 16'hffdf); smp(16'h0000); smp(16'h0000);
    // R7: two-channel AND
    tag = "R7"; arm(); cfg(2'd3, 16'hffff); cfg(2'd2, 16'h0000);
    cfg(2'd0, 16'hfffc); cfg(2'd1, 16'h0003);
    smp(16'h0001); smp(16'h0002); smp(16'h0003);
    // R10: no history after reset blocks edges
    do_reset(); tag = "R10";
    cfg(2'd2, 16'h0001); smp(16'h0001); smp(16'h0001); smp(16'h0000);
    // R2: write in same cycle as a sample uses old config
    tag = "R2"; arm(); cfg(2'd2, 16'h0000); cfg(2'd0, 16'hfffe); cfg(2'd1, 16'h0001);
    step(1, 16'h0001, 1, 2'd1, 16'h0000, 0); smp(16'h0001);
    // random phase
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) cfg(2'($urandom_range(0, 3)), 16'($urandom) | 16'hfff0);
      else if (r < 10) arm();
      else step($urandom_range(0, 3) != 0, 16'($urandom_range(0, 15)), 0, 0, '0, 0);
    end
    @(negedge clk); compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule